// File: doc/BRIEF.md
# Receive Completion Interrupt Coalescer

This block moderates the receive-done interrupt of a descriptor-ring copy engine. Instead of interrupting the host on every finished descriptor, it counts completion pulses and raises its status bit only when the number of pending completions passes a programmable count limit, or when the oldest pending completion has waited longer than a programmable age limit. The age is measured in coarse units, each unit being a parameterised number of pulses on a free-running tick input (twenty one-microsecond ticks by default).

Software programs the block through a plain register write port. A configuration word holds the coalescing enable and both limits. A status word holds the receive-done bit, which is cleared by writing a one to it. An enable word masks the interrupt line. With coalescing switched off, every completion sets the status bit directly. All pins are plain control and status signals: there is no data stream and no back-pressure.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset the status bit, the enable bit and the interrupt line are 0, and the configuration word holds coalescing on, count limit 20 and age limit 20 (value 0x0000_9414).
- R2: With coalescing on (config bit 15 = 1), the status bit is set at the clock edge where a completion makes the pending count greater than the count limit in config bits [14:8].
- R3: With coalescing on, the status bit is set one cycle after the pending age, in units of TICKS_PER_UNIT tick pulses, becomes greater than the age limit in config bits [6:0].
- R4: Tick pulses seen while no completion is pending add no age: the age restarts from zero with the first pending completion.
- R5: Setting the status bit clears both the pending count and the age, so the next interrupt needs a fresh count or age.
- R6: With coalescing off (config bit 15 = 0), every completion pulse sets the status bit at the next clock edge.
- R7: A write to the status word at offset 0x220 with bit 16 = 1 clears the status bit; a write with bit 16 = 0 leaves it unchanged. Config lives at offset 0x20C and the enable word at 0x228; writes to other offsets change nothing.
- R8: A completion in the same cycle as a status clear is kept: it counts toward the next interrupt. If a set and a clear fall in the same cycle, the set wins.
- R9: The interrupt line is high exactly when the status bit and enable bit 16 (offset 0x228) are both 1.
- R10: The status and enable word outputs carry their bit at position 16 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpl_pulse | input | 1 | One pulse per finished receive descriptor |
| us_tick | input | 1 | Time base pulse, one per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rx_done_sts | output | 1 | Receive-done status bit |
| sts_word | output | 32 | Status word view |
| ena_word | output | 32 | Enable word view |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach from the ports are the coincidences: a completion landing in the very cycle software clears the status, a set and a clear in the same cycle, and a limit lowered below an already accumulated count. Directed sequences place a clear exactly on a completion with a count limit of one, and a long random phase with small limits, dense completions, random ticks and frequent register writes makes the age and count limits hit together with clears and reconfiguration, all compared cycle by cycle against a bench model.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int THR_W  = 7;

  localparam logic [ADDR_W-1:0] OFS_CFG = 12'h20C;
  localparam logic [ADDR_W-1:0] OFS_STS = 12'h220;
  localparam logic [ADDR_W-1:0] OFS_ENA = 12'h228;

  localparam int BIT_RXDONE  = 16;
  localparam int BIT_COAL_EN = 15;
  localparam int CNT_LSB     = 8;
  localparam int AGE_LSB     = 0;

  localparam logic [THR_W-1:0] RST_CNT_LIM = 7'd20;
  localparam logic [THR_W-1:0] RST_AGE_LIM = 7'd20;

  typedef struct packed {
    logic             coal_on;
    logic [THR_W-1:0] cnt_lim;
    logic [THR_W-1:0] age_lim;
  } coal_cfg_t;
endpackage

// File: rtl/coal_regs.sv
module coal_regs
  import coal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output coal_cfg_t         cfg,
  output logic              ena_q,
  output logic              clr_req
);
  logic hit_cfg, hit_ena, hit_sts;

  assign hit_cfg = wr_en && (wr_addr == OFS_CFG);
  assign hit_ena = wr_en && (wr_addr == OFS_ENA);
  assign hit_sts = wr_en && (wr_addr == OFS_STS);
  assign clr_req = hit_sts && wr_data[BIT_RXDONE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.coal_on <= 1'b1;
      cfg.cnt_lim <= RST_CNT_LIM;
      cfg.age_lim <= RST_AGE_LIM;
    end else if (hit_cfg) begin
      cfg.coal_on <= wr_data[BIT_COAL_EN];
      cfg.cnt_lim <= wr_data[CNT_LSB +: THR_W];
      cfg.age_lim <= wr_data[AGE_LSB +: THR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ena_q <= 1'b0;
    else if (hit_ena) ena_q <= wr_data[BIT_RXDONE];
  end

  logic unused_wdata;
  assign unused_wdata = ^{wr_data[DATA_W-1:BIT_RXDONE+1], wr_data[CNT_LSB-1:THR_W]};

  // R7: writes elsewhere leave the enable untouched
  p_ena_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_ena |=> $stable(ena_q));
endmodule

// File: rtl/coal_pend_cnt.sv
module coal_pend_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_comb begin
    if (inc && (cnt_q != CNT_MAX)) cnt_next = cnt_q + 1'b1;
    else                           cnt_next = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= cnt_next;
  end
endmodule

// File: rtl/coal_age_timer.sv
module coal_age_timer #(
  parameter int TICKS_PER_UNIT = 20,
  parameter int UNIT_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic              tick,
  output logic [UNIT_W-1:0] units_q
);
  localparam int PRE_W = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICKS_PER_UNIT - 1);
  localparam logic [UNIT_W-1:0] UNITS_MAX = '1;

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (clr || !run) begin
      pre_q   <= '0;
      units_q <= '0;
    end else if (tick) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (units_q != UNITS_MAX) units_q <= units_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R4: no age builds up while nothing is pending
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (units_q == '0));
endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
  import coal_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_pulse,
  input  logic              us_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rx_done_sts,
  output logic [DATA_W-1:0] sts_word,
  output logic [DATA_W-1:0] ena_word,
  output logic              irq
);
  localparam int CNT_W  = THR_W + 1;
  localparam int UNIT_W = THR_W + 1;

  coal_cfg_t         cfg;
  logic              ena_q, clr_req;
  logic [CNT_W-1:0]  pend_q, pend_next;
  logic [UNIT_W-1:0] age_q;
  logic              pending, fire_cnt, fire_age, fire_direct, fire;
  logic              sts_q;

  coal_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg     (cfg),
    .ena_q   (ena_q),
    .clr_req (clr_req)
  );

  coal_pend_cnt #(.CNT_W(CNT_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (cpl_pulse),
    .clr      (fire),
    .cnt_q    (pend_q),
    .cnt_next (pend_next)
  );

  assign pending = (pend_q != '0);

  coal_age_timer #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .UNIT_W(UNIT_W)) u_age (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (pending),
    .clr     (fire),
    .tick    (us_tick),
    .units_q (age_q)
  );

  assign fire_cnt    = cfg.coal_on && (pend_next > {1'b0, cfg.cnt_lim});
  assign fire_age    = cfg.coal_on && pending && (age_q > {1'b0, cfg.age_lim});
  assign fire_direct = !cfg.coal_on && cpl_pulse;
  assign fire        = fire_cnt || fire_age || fire_direct;

  // set takes priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sts_q <= 1'b0;
    else if (fire)    sts_q <= 1'b1;
    else if (clr_req) sts_q <= 1'b0;
  end

  assign rx_done_sts = sts_q;
  assign irq         = sts_q && ena_q;

  always_comb begin
    sts_word = '0;
    ena_word = '0;
    sts_word[BIT_RXDONE] = sts_q;
    ena_word[BIT_RXDONE] = ena_q;
  end

  // R6: direct mode sets status on each completion
  p_direct_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.coal_on && cpl_pulse) |=> sts_q);

  // R7: a clear with no competing set drops the status
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !fire) |=> !sts_q);

  // R8: status is sticky until cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q && !clr_req) |=> sts_q);

  // R5: firing empties both counter and timer
  p_fire_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pend_q == '0 && age_q == '0));

  // R2: a count beyond the limit never survives a cycle
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.coal_on && pend_q > {1'b0, cfg.cnt_lim}) |=> (pend_q == '0));
endmodule

// File: tb/rx_irq_coalescer_bench.sv
module rx_irq_coalescer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpl_pulse = 1'b0, us_tick = 1'b0, wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rx_done_sts, irq;
  logic [31:0] sts_word, ena_word;

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // bench model state
  bit m_sts, m_ena, m_on;
  int m_cl, m_al, m_pend, m_elapsed;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_irq_coalescer #(.TICKS_PER_UNIT(UNIT)) u_rx_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .cpl_pulse(cpl_pulse), .us_tick(us_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rx_done_sts(rx_done_sts), .sts_word(sts_word), .ena_word(ena_word), .irq(irq)
  );

  function automatic logic [31:0] bit16(bit v);
    return {15'd0, v, 16'd0};
  endfunction

  task automatic model_reset();
    m_sts = 0; m_ena = 0; m_on = 1; m_cl = 20; m_al = 20; m_pend = 0; m_elapsed = 0;
  endtask

  task automatic model_step(bit d, bit t, bit we, logic [11:0] a, logic [31:0] w);
    int np;
    bit f;
    np = (d && m_pend < 255) ? m_pend + 1 : m_pend;
    f = (m_on && np > m_cl) ||
        (m_on && m_pend != 0 && m_elapsed >= (m_al + 1) * UNIT) ||
        (!m_on && d);
    if (f) begin
      m_sts = 1; m_pend = 0; m_elapsed = 0;
    end else begin
      if (m_pend == 0) m_elapsed = 0;
      else if (t)      m_elapsed++;
      m_pend = np;
      if (we && a == 12'h220 && w[16]) m_sts = 0;
    end
    if (we && a == 12'h228) m_ena = w[16];
    if (we && a == 12'h20C) begin
      m_on = w[15]; m_cl = int'(w[14:8]); m_al = int'(w[6:0]);
    end
  endtask

  task automatic compare();
    checks++;
    if (rx_done_sts !== m_sts) begin
      fails++; $display("FAIL %s status act=%0b exp=%0b", cur_req, rx_done_sts, m_sts);
    end
    if (irq !== (m_sts & m_ena)) begin
      fails++; $display("FAIL %s irq act=%0b exp=%0b", cur_req, irq, m_sts & m_ena);
    end
    if (sts_word !== bit16(m_sts) || ena_word !== bit16(m_ena)) begin
      fails++; $display("FAIL %s words act=%h/%h exp=%h/%h", cur_req,
                        sts_word, ena_word, bit16(m_sts), bit16(m_ena));
    end
  endtask

  // one cycle: check outputs of the previous edge, then drive and predict
  task automatic cyc(bit d, bit t, bit we = 0, logic [11:0] a = '0, logic [31:0] w = '0);
    @(negedge clk);
    compare();
    cpl_pulse = d; us_tick = t; wr_en = we; wr_addr = a; wr_data = w;
    model_step(d, t, we, a, w);
  endtask

  task automatic expect_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values, then default count limit of 20
    cur_req = "R1";
    cyc(0, 0);
    expect_bit("R1 reset status", rx_done_sts, 1'b0);
    expect_bit("R1 reset irq", irq, 1'b0);
    cyc(0, 0, 1, 12'h228, 32'h0001_0000);
    cur_req = "R1 R2 R9";
    for (int i = 0; i < 20; i++) cyc(1, 0);
    cyc(0, 0);
    expect_bit("R1 twenty completions under default limit", irq, 1'b0);
    cyc(1, 0);
    cyc(0, 0);
    expect_bit("R2 21st completion fires", irq, 1'b1);

    // R7: clear with bit16=0 ignored, with bit16=1 clears; other offset ignored
    cur_req = "R7";
    cyc(0, 0, 1, 12'h220, 32'hFFFE_FFFF);
    cyc(0, 0, 1, 12'h224, 32'hFFFF_FFFF);
    cyc(0, 0);
    expect_bit("R7 zero bit and foreign offset keep status", rx_done_sts, 1'b1);
    cyc(0, 0, 1, 12'h220, 32'h0001_0000);
    cyc(0, 0);
    expect_bit("R7 write-one clears", rx_done_sts, 1'b0);

    // R3/R4: idle ticks add nothing, then age limit 2 -> fires after 9 ticks
    cur_req = "R4";
    cyc(0, 0, 1, 12'h20C, 32'h0000_E402);
    for (int i = 0; i < 40; i++) cyc(0, 1);
    cur_req = "R3 R4";
    cyc(1, 1);
    for (int i = 0; i < 9; i++) cyc(0, 1);
    cyc(0, 0);
    expect_bit("R4 no fire before full age", rx_done_sts, 1'b0);
    cyc(0, 0);
    expect_bit("R3 age limit fires", rx_done_sts, 1'b1);

    // R5: counters restart after a fire
    cur_req = "R5";
    cyc(0, 0, 1, 12'h220, 32'h0001_0000);
    for (int i = 0; i < 12; i++) cyc(0, 1);
    cyc(0, 0);
    expect_bit("R5 no second fire without new completion", rx_done_sts, 1'b0);

    // R6: coalescing off
    cur_req = "R6";
    cyc(0, 0, 1, 12'h20C, 32'h0000_7F7F);
    cyc(1, 0);
    cyc(0, 0);
    expect_bit("R6 direct set", rx_done_sts, 1'b1);
    cyc(1, 0, 1, 12'h220, 32'h0001_0000);
    cyc(0, 0);
    expect_bit("R8 set wins over clear", rx_done_sts, 1'b1);

    // R8: completion alongside a clear, count limit 1
    cur_req = "R8";
    cyc(0, 0, 1, 12'h20C, 32'h0000_817F);
    cyc(0, 0, 1, 12'h220, 32'h0001_0000);
    cyc(1, 0);
    cyc(1, 0);
    cyc(0, 0);
    expect_bit("R8 limit 1 fires on second", rx_done_sts, 1'b1);
    cyc(1, 0, 1, 12'h220, 32'h0001_0000);
    cyc(0, 0);
    expect_bit("R8 clear applied", rx_done_sts, 1'b0);
    cyc(1, 0);
    cyc(0, 0);
    expect_bit("R8 completion at clear counted", rx_done_sts, 1'b1);

    // R9/R10: mask off
    cur_req = "R9 R10";
    cyc(0, 0, 1, 12'h228, 32'hFFFE_FFFF);
    cyc(0, 0);
    expect_bit("R9 masked irq", irq, 1'b0);
    expect_bit("R10 status word bit", sts_word[16], 1'b1);

    // random mix, all requirements against the model
    cur_req = "R2 R3 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 6000; i++) begin
      bit d, t, we;
      logic [11:0] a;
      logic [31:0] w;
      int sel;
      d = ($urandom_range(99) < 40);
      t = ($urandom_range(99) < 50);
      we = ($urandom_range(99) < 8);
      sel = $urandom_range(3);
      w = $urandom;
      case (sel)
        0: begin
          a = 12'h20C;
          w = 32'h0;
          w[15] = ($urandom_range(9) < 8);
          w[14:8] = 7'($urandom_range(6));
          w[6:0] = 7'($urandom_range(4));
        end
        1: a = 12'h220;
        2: a = 12'h228;
        default: a = 12'h100;
      endcase
      cyc(d, t, we, a, w);
    end
    cyc(0, 0);
    finish_run();
  end
endmodule